// File: doc/BRIEF.md
# Paged Extended Data Read Window

This block sits between a CPU data-read port and two memory spaces. It takes a 16-bit effective address. When the address's top bit is clear, the read goes straight to local data space with no added latency. When the top bit is set, the address opens a window into a larger 24-bit extended space. A 10-bit page register supplies the upper address bits: its nine low bits sit above the fifteen low bits of the effective address. The page register's top bit picks the target. A clear bit means extended SRAM or the external parallel memory, reached through a request/valid handshake. A set bit means an alternate space, flagged by its own select line, with no memory request raised.

Software sets up a windowed read in two steps. It first writes the page register. It then reads through a pointer whose bit 15 is set. A read can be a byte, a word or a double word, and it can repeat a given number of times as a burst, with the pointer advancing after each access. Every window read pays one cycle of overhead before the memory request rises. After that the accesses pipeline. With a zero-wait memory, the first two accesses of a burst finish within three cycles, and each later one takes a single cycle.

Top module: `xwin_read_unit`

## Requirements
- R1: Synchronous active-high reset clears the page register to 0, drops `mem_req`, `alt_sel` and `rsp_valid`, and leaves `rd_ready` high.
- R2: For a read with effective-address bit 15 = 1 and page bit 9 = 0, `mem_req` rises and `mem_addr` = {page[8:0], ea[14:0]}. Word and double-word reads force address bit 0 to 0.
- R3: For a read with effective-address bit 15 = 0, `local_sel` is asserted and `mem_req` stays low. A request in cycle k gives `rsp_valid` in cycle k+1.
- R4: For a read with effective-address bit 15 = 1 and page bit 9 = 1, `alt_sel` is asserted with `mem_req` low, and the data comes from `alt_rdata`.
- R5: A window read costs one overhead cycle. A request in cycle k, answered by a memory with no wait state, gives `rsp_valid` in cycle k+2. Each wait state adds one cycle.
- R6: `rd_rep` = n makes n+1 accesses. The pointer advances by the access size each time. With a zero-wait memory, responses come in consecutive cycles.
- R7: `rd_size` encoding: 0 = byte, 1 = word, 2 = double word. A byte read uses pointer bit 0 as the lane select. Bit 0 = 1 gives `mem_be` = 2'b10 and returns bits [15:8]. Bit 0 = 0 gives `mem_be` = 2'b01 and returns bits [7:0]. The result is zero-extended.
- R8: A word read ignores pointer bit 0, drives `mem_be` = 2'b11, and returns the whole 16-bit word.
- R9: A double-word read makes two word accesses, at pointer p and then p+2. It gives one response, {word at p+2, word at p}.
- R10: `mem_req` and `mem_addr` hold steady until the memory strobes `mem_rvalid`.
- R11: While a read is in progress, `rd_ready` is low and any new `rd_req` is ignored.
- R12: The page value is captured when a request is accepted. A page write during a burst affects only later requests.
- R13: The pointer advances only within its low 15 bits, so it wraps inside the window, and bit 15 never changes during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 10 | New page value |
| rd_req | input | 1 | Read request, taken when `rd_ready` is high |
| rd_addr | input | 16 | Effective address (pointer) |
| rd_size | input | 2 | 0 byte, 1 word, 2 double word |
| rd_rep | input | 8 | Extra repeats of the read |
| rd_ready | output | 1 | Ready to take a request |
| rsp_valid | output | 1 | Read result valid, one cycle per access |
| rsp_data | output | 32 | Read result |
| local_sel | output | 1 | Local data-space access this cycle |
| local_addr | output | 16 | Local data-space address |
| local_rdata | input | 16 | Local data-space word |
| mem_req | output | 1 | Extended-memory read request |
| mem_addr | output | 24 | Translated extended address (also used by the alternate space) |
| mem_be | output | 2 | Byte-lane select |
| mem_rvalid | input | 1 | Extended-memory data strobe |
| mem_rdata | input | 16 | Extended-memory word |
| alt_sel | output | 1 | Alternate-space access this cycle |
| alt_rdata | input | 16 | Alternate-space word |

## Verification
The assertions assume that the memory raises `mem_rvalid` only while `mem_req` is high, and that local and alternate data are valid in the same cycle their select is high. The bench's memory model derives its strobe from `mem_req` through a wait-state counter, and it derives all three data inputs combinationally from the address outputs. The assertions also assume that reset is applied from the first clock, and the bench holds it for several cycles. `rd_size` is kept to the three defined codes.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

  localparam int XW_EA_W = 16;
  localparam int XW_PG_W = 10;
  localparam int XW_XA_W = (XW_PG_W - 1) + (XW_EA_W - 1);
  localparam int XW_DW   = 16;
  localparam int XW_RW   = 2 * XW_DW;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_EXT   = 2'd1,
    TGT_ALT   = 2'd2
  } xw_tgt_e;

  // page bits sit directly above the in-window offset
  function automatic logic [XW_XA_W-1:0] xw_xlate(input logic [XW_PG_W-2:0] pg,
                                                  input logic [XW_EA_W-1:0] ea);
    return {pg, ea[XW_EA_W-2:0]};
  endfunction

  // byte reads keep bit 0, wider reads are word aligned
  function automatic logic [XW_EA_W-1:0] xw_align(input logic [XW_EA_W-1:0] ea,
                                                  input logic [1:0] sz);
    return (sz == SZ_BYTE) ? ea : {ea[XW_EA_W-1:1], 1'b0};
  endfunction

  // pointer advance stays inside the low 15 bits
  function automatic logic [XW_EA_W-1:0] xw_step(input logic [XW_EA_W-1:0] ea,
                                                 input logic [1:0] sz);
    logic [XW_EA_W-2:0] lo;
    lo = ea[XW_EA_W-2:0] + ((sz == SZ_BYTE) ? 15'd1 : 15'd2);
    return {ea[XW_EA_W-1], lo};
  endfunction

  function automatic logic [1:0] xw_lanes(input logic lane, input logic [1:0] sz);
    if (sz != SZ_BYTE) return 2'b11;
    return lane ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [XW_DW-1:0] xw_pick(input logic [XW_DW-1:0] w,
                                               input logic lane,
                                               input logic [1:0] sz);
    if (sz != SZ_BYTE) return w;
    return lane ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

endpackage

// File: rtl/xwin_page_reg.sv
module xwin_page_reg
  import xwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [XW_PG_W-1:0] wdata,
  output logic [XW_PG_W-1:0] page
);

  logic [XW_PG_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst)     page_q <= '0;
    else if (we) page_q <= wdata;
  end

  assign page = page_q;

  a_r1_page_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page_q == '0));

endmodule

// File: rtl/xwin_target_dec.sv
module xwin_target_dec
  import xwin_pkg::*;
(
  input  logic    win_bit,
  input  logic    alt_bit,
  output xw_tgt_e tgt
);

  always_comb begin
    if (!win_bit)     tgt = TGT_LOCAL;
    else if (alt_bit) tgt = TGT_ALT;
    else              tgt = TGT_EXT;
  end

endmodule

// File: rtl/xwin_seq.sv
module xwin_seq
  import xwin_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic [XW_EA_W-1:0] rd_addr,
  input  logic [1:0]         rd_size,
  input  logic [REP_W-1:0]   rd_rep,
  input  logic [XW_PG_W-2:0] req_pg,
  input  xw_tgt_e            req_tgt,
  input  logic               mem_rvalid,
  output logic               busy,
  output logic [XW_EA_W-1:0] act_ea,
  output logic [1:0]         act_sz,
  output xw_tgt_e            act_tgt,
  output logic [XW_PG_W-2:0] act_pg,
  output logic               beat_go,
  output logic               last_beat,
  output logic               win_accept
);

  typedef enum logic {ST_IDLE, ST_XFER} st_e;

  st_e                st_q;
  logic [XW_EA_W-1:0] ea_q;
  logic [1:0]         sz_q;
  xw_tgt_e            tgt_q;
  logic [XW_PG_W-2:0] pg_q;
  logic [REP_W-1:0]   rep_q;
  logic               half_q;

  logic               idle;
  logic               act_half;
  logic [REP_W-1:0]   act_rep;
  logic               is_dw;
  logic               done_all;

  always_comb begin
    idle       = (st_q == ST_IDLE);
    act_ea     = idle ? rd_addr : ea_q;
    act_sz     = idle ? rd_size : sz_q;
    act_tgt    = idle ? req_tgt : tgt_q;
    act_pg     = idle ? req_pg  : pg_q;
    act_rep    = idle ? rd_rep  : rep_q;
    act_half   = idle ? 1'b0    : half_q;
    // local reads complete in the accept cycle; window reads wait one cycle
    if (idle)                  beat_go = rd_req && (req_tgt == TGT_LOCAL);
    else if (tgt_q == TGT_EXT) beat_go = mem_rvalid;
    else                       beat_go = 1'b1;
    is_dw      = (act_sz == SZ_DWORD);
    last_beat  = beat_go && (!is_dw || act_half);
    done_all   = last_beat && (act_rep == '0);
    win_accept = idle && rd_req && (req_tgt != TGT_LOCAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ea_q   <= '0;
      sz_q   <= SZ_BYTE;
      tgt_q  <= TGT_LOCAL;
      pg_q   <= '0;
      rep_q  <= '0;
      half_q <= 1'b0;
    end else begin
      if (idle && rd_req) begin
        ea_q   <= rd_addr;
        sz_q   <= rd_size;
        tgt_q  <= req_tgt;
        pg_q   <= req_pg;
        rep_q  <= rd_rep;
        half_q <= 1'b0;
      end
      if (beat_go) begin
        ea_q   <= xw_step(act_ea, act_sz);
        half_q <= is_dw && !act_half;
        if (last_beat) rep_q <= act_rep - 1'b1;
      end
      if (idle && rd_req && !done_all) st_q <= ST_XFER;
      else if (!idle && done_all)      st_q <= ST_IDLE;
    end
  end

  assign busy = !idle;

  // R10: address frozen while extended memory has not answered
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (!idle && tgt_q == TGT_EXT && !mem_rvalid) |=> (ea_q == $past(ea_q)) && (st_q == ST_XFER));

  // R13: window bit of the pointer never changes inside a burst
  a_r13_msb_kept: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(st_q == ST_XFER)) |-> (ea_q[XW_EA_W-1] == $past(ea_q[XW_EA_W-1])));

endmodule

// File: rtl/xwin_resp.sv
module xwin_resp
  import xwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_go,
  input  logic             last_beat,
  input  logic [1:0]       act_sz,
  input  logic             lane,
  input  logic [XW_DW-1:0] word_in,
  output logic             rsp_valid,
  output logic [XW_RW-1:0] rsp_data
);

  logic [XW_DW-1:0] lo_q;
  logic             vld_q;
  logic [XW_RW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= last_beat;
      if (beat_go && !last_beat) lo_q <= word_in;
      if (last_beat) begin
        if (act_sz == SZ_DWORD) dat_q <= {word_in, lo_q};
        else                    dat_q <= {{XW_DW{1'b0}}, xw_pick(word_in, lane, act_sz)};
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;

  // R7: byte results never carry data above bit 7
  a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (last_beat && act_sz == SZ_BYTE) |=> (rsp_data[XW_RW-1:8] == '0));

endmodule

// File: rtl/xwin_read_unit.sv
module xwin_read_unit
  import xwin_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               page_we,
  input  logic [XW_PG_W-1:0] page_wdata,
  input  logic               rd_req,
  input  logic [XW_EA_W-1:0] rd_addr,
  input  logic [1:0]         rd_size,
  input  logic [REP_W-1:0]   rd_rep,
  output logic               rd_ready,
  output logic               rsp_valid,
  output logic [XW_RW-1:0]   rsp_data,
  output logic               local_sel,
  output logic [XW_EA_W-1:0] local_addr,
  input  logic [XW_DW-1:0]   local_rdata,
  output logic               mem_req,
  output logic [XW_XA_W-1:0] mem_addr,
  output logic [1:0]         mem_be,
  input  logic               mem_rvalid,
  input  logic [XW_DW-1:0]   mem_rdata,
  output logic               alt_sel,
  input  logic [XW_DW-1:0]   alt_rdata
);

  logic [XW_PG_W-1:0] page;
  xw_tgt_e            req_tgt;
  logic               busy;
  logic [XW_EA_W-1:0] act_ea;
  logic [1:0]         act_sz;
  xw_tgt_e            act_tgt;
  logic [XW_PG_W-2:0] act_pg;
  logic               beat_go;
  logic               last_beat;
  logic               win_accept;
  logic [XW_DW-1:0]   beat_word;

  xwin_page_reg i_page (
    .clk(clk), .rst(rst), .we(page_we), .wdata(page_wdata), .page(page)
  );

  xwin_target_dec i_dec (
    .win_bit(rd_addr[XW_EA_W-1]), .alt_bit(page[XW_PG_W-1]), .tgt(req_tgt)
  );

  xwin_seq #(.REP_W(REP_W)) i_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_rep(rd_rep), .req_pg(page[XW_PG_W-2:0]), .req_tgt(req_tgt),
    .mem_rvalid(mem_rvalid), .busy(busy), .act_ea(act_ea), .act_sz(act_sz),
    .act_tgt(act_tgt), .act_pg(act_pg), .beat_go(beat_go), .last_beat(last_beat),
    .win_accept(win_accept)
  );

  always_comb begin
    case (act_tgt)
      TGT_LOCAL: beat_word = local_rdata;
      TGT_EXT:   beat_word = mem_rdata;
      default:   beat_word = alt_rdata;
    endcase
  end

  xwin_resp i_resp (
    .clk(clk), .rst(rst), .beat_go(beat_go), .last_beat(last_beat),
    .act_sz(act_sz), .lane(act_ea[0]), .word_in(beat_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign rd_ready   = !busy;
  assign local_sel  = (busy || rd_req) && (act_tgt == TGT_LOCAL);
  assign local_addr = xw_align(act_ea, act_sz);
  assign mem_req    = busy && (act_tgt == TGT_EXT);
  assign alt_sel    = busy && (act_tgt == TGT_ALT);
  assign mem_addr   = xw_xlate(act_pg, xw_align(act_ea, act_sz));
  assign mem_be     = xw_lanes(act_ea[0], act_sz);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !alt_sel && !rsp_valid && rd_ready));

  a_r3_local_exclusive: assert property (@(posedge clk) disable iff (rst)
    local_sel |-> (!mem_req && !alt_sel));

  a_r4_alt_no_request: assert property (@(posedge clk) disable iff (rst)
    alt_sel |-> !mem_req);

  a_r5_window_overhead: assert property (@(posedge clk) disable iff (rst)
    win_accept |=> !rsp_valid);

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_be == 2'b11) |-> !mem_addr[0]);

  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/test_xwin_read_unit.sv
`timescale 1ns/1ps
module test_xwin_read_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        page_we = 1'b0;
  logic [9:0]  page_wdata = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_size = '0;
  logic [7:0]  rd_rep = '0;
  logic        rd_ready, rsp_valid, local_sel, mem_req, mem_rvalid, alt_sel;
  logic [31:0] rsp_data;
  logic [15:0] local_addr, local_rdata, mem_rdata, alt_rdata;
  logic [23:0] mem_addr;
  logic [1:0]  mem_be;

  int checks = 0, errors = 0, cyc = 0, req_cyc = 0;
  int wait_cfg = 0, wcnt = 0;
  int n_rsp, n_mb, n_ab, n_lb, n_hold_bad;
  logic saw_busy, stall_v;
  logic [23:0] stall_a;
  logic [31:0] rsp_d [16];
  int          rsp_c [16];
  logic [23:0] mb_a [16];
  logic [1:0]  mb_be [16];
  logic [23:0] ab_a;
  logic [15:0] lb_a;

  always #10 clk = ~clk;

  function automatic logic [15:0] mw(input logic [23:0] a);
    logic [23:0] w;
    w = {a[23:1], 1'b0};
    return {w[7:0] ^ 8'h5A, w[15:8] ^ w[23:16]};
  endfunction
  function automatic logic [15:0] lw(input logic [15:0] a);
    return {a[15:1], 1'b0} ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] aw(input logic [23:0] a);
    return a[15:0] + {a[23:16], 8'h00} + 16'h1111;
  endfunction

  assign mem_rdata   = mw(mem_addr);
  assign alt_rdata   = aw(mem_addr);
  assign local_rdata = lw(local_addr);
  assign mem_rvalid  = mem_req && (wcnt >= wait_cfg);

  xwin_read_unit i_xwin_read_unit (
    .clk(clk), .rst(rst), .page_we(page_we), .page_wdata(page_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_rep(rd_rep),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .local_sel(local_sel), .local_addr(local_addr), .local_rdata(local_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .alt_sel(alt_sel), .alt_rdata(alt_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_rvalid) wcnt <= wcnt + 1;
    else                        wcnt <= 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (n_rsp < 16) begin rsp_d[n_rsp] = rsp_data; rsp_c[n_rsp] = cyc; end
        n_rsp = n_rsp + 1;
      end
      if (mem_req && mem_rvalid) begin
        if (n_mb < 16) begin mb_a[n_mb] = mem_addr; mb_be[n_mb] = mem_be; end
        n_mb = n_mb + 1;
      end
      if (alt_sel) begin ab_a = mem_addr; n_ab = n_ab + 1; end
      if (local_sel) begin lb_a = local_addr; n_lb = n_lb + 1; end
      if (mem_req && !mem_rvalid) begin
        if (stall_v && mem_addr != stall_a) n_hold_bad = n_hold_bad + 1;
        stall_v = 1'b1; stall_a = mem_addr;
      end else stall_v = 1'b0;
      if (!rd_ready) saw_busy = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clear_logs();
    n_rsp = 0; n_mb = 0; n_ab = 0; n_lb = 0; n_hold_bad = 0;
    saw_busy = 1'b0; stall_v = 1'b0;
  endtask

  task automatic set_page(input logic [9:0] v);
    @(posedge clk); #2; page_we = 1'b1; page_wdata = v;
    @(posedge clk); #2; page_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] ea, input logic [1:0] sz, input logic [7:0] rep);
    @(posedge clk); #2;
    rd_addr = ea; rd_size = sz; rd_rep = rep; rd_req = 1'b1; req_cyc = cyc;
    @(posedge clk); #2; rd_req = 1'b0;
  endtask

  task automatic run_req(input logic [15:0] ea, input logic [1:0] sz, input logic [7:0] rep);
    clear_logs();
    pulse(ea, sz, rep);
    repeat (30) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 rd_ready", {31'b0, rd_ready}, 32'd1);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 alt_sel", {31'b0, alt_sel}, 32'd0);
    run_req(16'h8010, 2'd1, 8'd0);
    chk("R1 page zero addr", {8'b0, mb_a[0]}, 32'h000010);
  endtask

  task automatic t_local();
    run_req(16'h1234, 2'd1, 8'd0);
    chk("R3 local rsp count", n_rsp, 1);
    chk("R3 local latency", rsp_c[0] - req_cyc, 1);
    chk("R3 local data", rsp_d[0], {16'b0, lw(16'h1234)});
    chk("R3 no mem beat", n_mb, 0);
    run_req(16'h1235, 2'd1, 8'd0);
    chk("R8 local odd word addr", {16'b0, lb_a}, 32'h1234);
    chk("R8 local odd word data", rsp_d[0], {16'b0, lw(16'h1234)});
  endtask

  task automatic t_ext_single();
    set_page(10'd2);
    run_req(16'h8801, 2'd0, 8'd0);
    chk("R2 ext byte addr", {8'b0, mb_a[0]}, 32'h010801);
    chk("R7 odd lane be", {30'b0, mb_be[0]}, 32'd2);
    chk("R7 odd lane data", rsp_d[0], {24'b0, mw(24'h010800) >> 8});
    chk("R5 ext latency", rsp_c[0] - req_cyc, 2);
    run_req(16'h8800, 2'd0, 8'd0);
    chk("R7 even lane be", {30'b0, mb_be[0]}, 32'd1);
    chk("R7 even lane data", rsp_d[0], {24'b0, mw(24'h010800) & 16'h00FF});
    run_req(16'h8803, 2'd1, 8'd0);
    chk("R8 ext word aligned", {8'b0, mb_a[0]}, 32'h010802);
    chk("R8 ext word be", {30'b0, mb_be[0]}, 32'd3);
    chk("R8 ext word data", rsp_d[0], {16'b0, mw(24'h010802)});
  endtask

  task automatic t_wait();
    wait_cfg = 3;
    run_req(16'h8004, 2'd1, 8'd0);
    chk("R5 latency with waits", rsp_c[0] - req_cyc, 5);
    chk("R10 held while stalled", n_hold_bad, 0);
    chk("R10 one beat", n_mb, 1);
    wait_cfg = 0;
  endtask

  task automatic t_dword();
    set_page(10'd5);
    run_req(16'h8100, 2'd2, 8'd0);
    chk("R9 beat count", n_mb, 2);
    chk("R9 first addr", {8'b0, mb_a[0]}, 32'h028100);
    chk("R9 second addr", {8'b0, mb_a[1]}, 32'h028102);
    chk("R9 one response", n_rsp, 1);
    chk("R9 data", rsp_d[0], {mw(24'h028102), mw(24'h028100)});
    chk("R9 latency", rsp_c[0] - req_cyc, 3);
  endtask

  task automatic t_burst();
    set_page(10'd1);
    run_req(16'h8200, 2'd1, 8'd4);
    chk("R6 burst count", n_rsp, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R6 burst latency", rsp_c[i] - req_cyc, 2 + i);
      chk("R6 burst addr", {8'b0, mb_a[i]}, 32'h008200 + 2 * i);
      chk("R6 burst data", rsp_d[i], {16'b0, mw(24'h008200 + 24'(2 * i))});
    end
    run_req(16'h0101, 2'd0, 8'd2);
    chk("R6 local byte burst count", n_rsp, 3);
    chk("R6 local burst latency", rsp_c[2] - req_cyc, 3);
    chk("R6 byte 0", rsp_d[0], {24'b0, lw(16'h0100) >> 8});
    chk("R6 byte 1", rsp_d[1], {24'b0, lw(16'h0102) & 16'h00FF});
    chk("R6 byte 2", rsp_d[2], {24'b0, lw(16'h0102) >> 8});
  endtask

  task automatic t_wrap();
    run_req(16'hFFFE, 2'd1, 8'd1);
    chk("R13 first addr", {8'b0, mb_a[0]}, 32'h00FFFE);
    chk("R13 wrapped addr", {8'b0, mb_a[1]}, 32'h008000);
  endtask

  task automatic t_alt();
    set_page(10'h201);
    run_req(16'h8040, 2'd1, 8'd0);
    chk("R4 no mem beat", n_mb, 0);
    chk("R4 alt beat", n_ab, 1);
    chk("R4 alt addr", {8'b0, ab_a}, 32'h008040);
    chk("R4 alt data", rsp_d[0], {16'b0, aw(24'h008040)});
    chk("R4 alt latency", rsp_c[0] - req_cyc, 2);
  endtask

  task automatic t_busy();
    set_page(10'd1);
    clear_logs();
    pulse(16'h8300, 2'd1, 8'd3);
    rd_addr = 16'h0010; rd_rep = 8'd0; rd_req = 1'b1;
    @(posedge clk); #2; rd_req = 1'b0;
    repeat (30) @(posedge clk);
    #2;
    chk("R11 busy seen", {31'b0, saw_busy}, 32'd1);
    chk("R11 responses", n_rsp, 4);
    chk("R11 no local access", n_lb, 0);
    chk("R11 last data", rsp_d[3], {16'b0, mw(24'h008306)});
  endtask

  task automatic t_page_latch();
    set_page(10'd3);
    wait_cfg = 1;
    clear_logs();
    pulse(16'h8000, 2'd1, 8'd3);
    @(posedge clk); #2; page_we = 1'b1; page_wdata = 10'd7;
    @(posedge clk); #2; page_we = 1'b0;
    repeat (30) @(posedge clk);
    #2;
    chk("R12 beats", n_mb, 4);
    for (int i = 0; i < 4; i++)
      chk("R12 latched page", {23'b0, mb_a[i][23:15]}, 32'd3);
    wait_cfg = 0;
    run_req(16'h8000, 2'd1, 8'd0);
    chk("R12 new page", {8'b0, mb_a[0]}, 32'h038000);
  endtask

  initial begin
    clear_logs();
    repeat (4) @(posedge clk);
    #2; rst = 1'b0;
    @(posedge clk); #2;
    t_reset();
    t_local();
    t_ext_single();
    t_wait();
    t_dword();
    t_burst();
    t_wrap();
    t_alt();
    t_busy();
    t_page_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule